// File: doc/BRIEF.md
# Locked Atomic Read-Modify-Write Controller

This block carries out one locked atomic operation at a time against a single cache line. It handles three operations: add, exchange and compare-and-swap. A request names the operation, a byte address and up to two operands. The controller first checks that the operand fits inside one line and that the operation code is known. It then waits until the local store buffer reports empty, so every earlier local load and store has completed. Next it locks the line and asks the coherence fabric for exclusive ownership. Once ownership is granted it reads the whole line, merges the new operand value into it, writes it back and drops the lock.

While the lock is held, a coherence snoop that targets the locked line gets no reply. The controller counts such snoops. After release it answers each one with the line as it stands after the operation. Snoops to any other line are answered on the next cycle, as if no operation were in progress. A new request is not accepted until every deferred snoop has been answered.

Top module: `atomic_rmw_ctrl`

## Requirements
- R1: After a request is accepted, no ownership request and no cache read is issued while `sb_empty` is low. `own_req` rises only on the cycle after a cycle in which `sb_empty` was high.
- R2: A cache read is issued only on the cycle after `own_gnt` is seen. The line stays locked from the ownership request until the write has been made.
- R3: A snoop whose line equals the locked line, arriving while the lock is held, gets no response during the lock.
- R4: A snoop to any line other than the locked line is answered on the following cycle with `snp_rsp_line` equal to the snooped line and `snp_rsp_dvld` = 0.
- R5: After release, each deferred snoop gets one response, one at a time and in cycles without an incoming snoop. Each such response has `snp_rsp_dvld` = 1 and `snp_rsp_data` equal to the line after the operation.
- R6: Operation code 2'b00 (add) writes old + `req_opa` modulo 2^(8·DATA_BYTES) and returns the old value with `rsp_ok` = 1. The operand sits at bits [8·off +: 8·DATA_BYTES] of the line, where off is the low log2(LINE_BYTES) bits of `req_addr`.
- R7: Operation code 2'b01 (exchange) writes `req_opa` and returns the old value with `rsp_ok` = 1.
- R8: Operation code 2'b10 (compare-and-swap) writes `req_opa` only when the old value equals `req_opb`, and then reports `rsp_ok` = 1. Otherwise it makes no cache write and reports `rsp_ok` = 0. In both cases it returns the old value.
- R9: A request is rejected if off + DATA_BYTES > LINE_BYTES or if its operation code is 2'b11. The rejection comes on the cycle after acceptance as `rsp_valid` with `rsp_err` = 1, `rsp_old` = 0 and `rsp_ok` = 0, with no lock, no ownership request and no cache access.
- R10: After reset, `req_ready` is 1 and all valid outputs are 0. `req_ready` goes low from acceptance of a valid request until the response has been given and all deferred snoops have been answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | 00 add, 01 exchange, 10 compare-and-swap |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_opa | input | 8·DATA_BYTES | Addend, or the new value |
| req_opb | input | 8·DATA_BYTES | Expected value for compare-and-swap |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request rejected |
| rsp_ok | output | 1 | Write made (compare-and-swap success) |
| rsp_old | output | 8·DATA_BYTES | Value read before the operation |
| sb_empty | input | 1 | Local store buffer is empty |
| own_req | output | 1 | Exclusive ownership request, held until granted |
| own_line | output | ADDR_W−log2(LINE_BYTES) | Line being requested |
| own_gnt | input | 1 | One-cycle ownership grant |
| cache_rd_en | output | 1 | Line read; data returns the next cycle |
| cache_wr_en | output | 1 | Line write |
| cache_line | output | ADDR_W−log2(LINE_BYTES) | Line index for read and write |
| cache_wdata | output | 8·LINE_BYTES | Line write data |
| cache_rdata | input | 8·LINE_BYTES | Line read data |
| snp_valid | input | 1 | Incoming snoop |
| snp_line | input | ADDR_W−log2(LINE_BYTES) | Snooped line |
| snp_rsp_valid | output | 1 | Snoop response strobe |
| snp_rsp_line | output | ADDR_W−log2(LINE_BYTES) | Line being answered |
| snp_rsp_dvld | output | 1 | Response carries line data |
| snp_rsp_data | output | 8·LINE_BYTES | Updated line for deferred answers |

## Verification
The assertions take four things for granted about the inputs. The grant arrives as a single-cycle pulse, and only while `own_req` is high. The cache returns read data exactly one cycle after `cache_rd_en`. At most one snoop arrives per cycle. No more than DEFER_MAX snoops hit the locked line during one operation. The stimulus meets these assumptions by construction. The bench's ownership model pulses the grant a fixed number of cycles after it sees the request, and its line memory has a registered one-cycle read. Snoops are driven as single-cycle pulses, with at most two of them aimed at a locked line per operation.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
  localparam logic [1:0] OP_ADD  = 2'd0;
  localparam logic [1:0] OP_XCHG = 2'd1;
  localparam logic [1:0] OP_CAS  = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_SBWAIT, S_OWN, S_READ, S_MODIFY, S_WRITE
  } rmw_state_e;
endpackage

// File: rtl/rmw_line_alu.sv
module rmw_line_alu #(
  parameter int LINE_BYTES = 16,
  parameter int DATA_BYTES = 4,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int DW     = DATA_BYTES * 8,
  localparam int OFF_W  = $clog2(LINE_BYTES)
) (
  input  logic [1:0]        op,
  input  logic [OFF_W-1:0]  off,
  input  logic [DW-1:0]     opa,
  input  logic [DW-1:0]     opb,
  input  logic [LINE_W-1:0] line_in,
  output logic [DW-1:0]     old_val,
  output logic [LINE_W-1:0] line_out,
  output logic              do_write
);
  import atomic_rmw_pkg::*;

  logic [LINE_W-1:0] shifted, mask, insert;
  logic [DW-1:0]     new_val;

  always_comb begin
    shifted = line_in >> {off, 3'b000};
    old_val = shifted[DW-1:0];
    case (op)
      OP_ADD:  begin new_val = old_val + opa; do_write = 1'b1; end
      OP_XCHG: begin new_val = opa;           do_write = 1'b1; end
      OP_CAS:  begin
        do_write = (old_val == opb);
        new_val  = do_write ? opa : old_val;
      end
      default: begin new_val = old_val; do_write = 1'b0; end
    endcase
    mask     = {{(LINE_W-DW){1'b0}}, {DW{1'b1}}} << {off, 3'b000};
    insert   = {{(LINE_W-DW){1'b0}}, new_val} << {off, 3'b000};
    line_out = (line_in & ~mask) | insert;
  end
endmodule

// File: rtl/rmw_sequencer.sv
module rmw_sequencer #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int DATA_BYTES = 4,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int DW     = DATA_BYTES * 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int TAG_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_opa,
  input  logic [DW-1:0]     req_opb,
  input  logic              sb_empty,
  input  logic              own_gnt,
  input  logic              defer_busy,
  input  logic [DW-1:0]     alu_old,
  input  logic [LINE_W-1:0] alu_line,
  input  logic              alu_write,
  output logic [1:0]        op_q,
  output logic [OFF_W-1:0]  off_q,
  output logic [DW-1:0]     opa_q,
  output logic [DW-1:0]     opb_q,
  output logic [TAG_W-1:0]  line_q,
  output logic              lock_q,
  output logic              own_req,
  output logic              cache_rd_en,
  output logic              cache_wr_en,
  output logic [LINE_W-1:0] cache_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              rsp_ok,
  output logic [DW-1:0]     rsp_old
);
  import atomic_rmw_pkg::*;

  rmw_state_e       st;
  logic [OFF_W:0]   end_byte;
  logic             reject;

  assign req_ready = (st == S_IDLE) && !defer_busy;
  assign end_byte  = {1'b0, req_addr[OFF_W-1:0]} + (OFF_W+1)'(DATA_BYTES);
  assign reject    = (end_byte > (OFF_W+1)'(LINE_BYTES)) || (req_op == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      op_q        <= '0;
      off_q       <= '0;
      opa_q       <= '0;
      opb_q       <= '0;
      line_q      <= '0;
      lock_q      <= 1'b0;
      own_req     <= 1'b0;
      cache_rd_en <= 1'b0;
      cache_wr_en <= 1'b0;
      cache_wdata <= '0;
      rsp_valid   <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_ok      <= 1'b0;
      rsp_old     <= '0;
    end else begin
      rsp_valid   <= 1'b0;
      cache_rd_en <= 1'b0;
      cache_wr_en <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid && req_ready) begin
          op_q   <= req_op;
          off_q  <= req_addr[OFF_W-1:0];
          line_q <= req_addr[ADDR_W-1:OFF_W];
          opa_q  <= req_opa;
          opb_q  <= req_opb;
          if (reject) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_ok    <= 1'b0;
            rsp_old   <= '0;
          end else begin
            st <= S_SBWAIT;
          end
        end
        S_SBWAIT: if (sb_empty) begin
          lock_q  <= 1'b1;
          own_req <= 1'b1;
          st      <= S_OWN;
        end
        S_OWN: if (own_gnt) begin
          own_req     <= 1'b0;
          cache_rd_en <= 1'b1;
          st          <= S_READ;
        end
        S_READ: st <= S_MODIFY;
        S_MODIFY: begin
          cache_wdata <= alu_line;
          cache_wr_en <= alu_write;
          rsp_old     <= alu_old;
          rsp_ok      <= alu_write;
          st          <= S_WRITE;
        end
        S_WRITE: begin
          lock_q    <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rmw_snoop_gate.sv
module rmw_snoop_gate #(
  parameter int TAG_W     = 12,
  parameter int LINE_W    = 128,
  parameter int DEFER_MAX = 4,
  localparam int CNT_W = $clog2(DEFER_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [TAG_W-1:0]  snp_line,
  input  logic              lock_q,
  input  logic [TAG_W-1:0]  lock_line,
  input  logic [LINE_W-1:0] final_line,
  output logic              defer_busy,
  output logic              snp_rsp_valid,
  output logic [TAG_W-1:0]  snp_rsp_line,
  output logic              snp_rsp_dvld,
  output logic [LINE_W-1:0] snp_rsp_data
);
  logic [CNT_W-1:0] pend;
  logic             hit;

  assign hit        = lock_q && (snp_line == lock_line);
  assign defer_busy = (pend != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend          <= '0;
      snp_rsp_valid <= 1'b0;
      snp_rsp_line  <= '0;
      snp_rsp_dvld  <= 1'b0;
      snp_rsp_data  <= '0;
    end else begin
      snp_rsp_valid <= 1'b0;
      if (snp_valid) begin
        if (hit) begin
          pend <= pend + CNT_W'(1);
        end else begin
          snp_rsp_valid <= 1'b1;
          snp_rsp_line  <= snp_line;
          snp_rsp_dvld  <= 1'b0;
          snp_rsp_data  <= '0;
        end
      end else if (defer_busy && !lock_q) begin
        snp_rsp_valid <= 1'b1;
        snp_rsp_line  <= lock_line;
        snp_rsp_dvld  <= 1'b1;
        snp_rsp_data  <= final_line;
        pend          <= pend - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/atomic_rmw_ctrl.sv
module atomic_rmw_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int DATA_BYTES = 4,
  parameter int DEFER_MAX  = 4,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int DW     = DATA_BYTES * 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int TAG_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_opa,
  input  logic [DW-1:0]     req_opb,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              rsp_ok,
  output logic [DW-1:0]     rsp_old,
  input  logic              sb_empty,
  output logic              own_req,
  output logic [TAG_W-1:0]  own_line,
  input  logic              own_gnt,
  output logic              cache_rd_en,
  output logic              cache_wr_en,
  output logic [TAG_W-1:0]  cache_line,
  output logic [LINE_W-1:0] cache_wdata,
  input  logic [LINE_W-1:0] cache_rdata,
  input  logic              snp_valid,
  input  logic [TAG_W-1:0]  snp_line,
  output logic              snp_rsp_valid,
  output logic [TAG_W-1:0]  snp_rsp_line,
  output logic              snp_rsp_dvld,
  output logic [LINE_W-1:0] snp_rsp_data
);
  logic [1:0]        op_q;
  logic [OFF_W-1:0]  off_q;
  logic [DW-1:0]     opa_q, opb_q, alu_old;
  logic [TAG_W-1:0]  lock_line;
  logic              lock_q, defer_busy, alu_write;
  logic [LINE_W-1:0] alu_line;

  assign own_line   = lock_line;
  assign cache_line = lock_line;

  rmw_sequencer #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .DATA_BYTES(DATA_BYTES)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
    .sb_empty(sb_empty), .own_gnt(own_gnt), .defer_busy(defer_busy),
    .alu_old(alu_old), .alu_line(alu_line), .alu_write(alu_write),
    .op_q(op_q), .off_q(off_q), .opa_q(opa_q), .opb_q(opb_q), .line_q(lock_line),
    .lock_q(lock_q), .own_req(own_req), .cache_rd_en(cache_rd_en),
    .cache_wr_en(cache_wr_en), .cache_wdata(cache_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_ok(rsp_ok), .rsp_old(rsp_old)
  );

  rmw_line_alu #(.LINE_BYTES(LINE_BYTES), .DATA_BYTES(DATA_BYTES)) u_alu (
    .op(op_q), .off(off_q), .opa(opa_q), .opb(opb_q), .line_in(cache_rdata),
    .old_val(alu_old), .line_out(alu_line), .do_write(alu_write)
  );

  rmw_snoop_gate #(.TAG_W(TAG_W), .LINE_W(LINE_W), .DEFER_MAX(DEFER_MAX)) u_gate (
    .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_line(snp_line),
    .lock_q(lock_q), .lock_line(lock_line), .final_line(cache_wdata),
    .defer_busy(defer_busy), .snp_rsp_valid(snp_rsp_valid),
    .snp_rsp_line(snp_rsp_line), .snp_rsp_dvld(snp_rsp_dvld),
    .snp_rsp_data(snp_rsp_data)
  );
endmodule

// File: rtl/atomic_rmw_chk.sv
module atomic_rmw_chk #(
  parameter int TAG_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             sb_empty,
  input logic             own_req,
  input logic             own_gnt,
  input logic             cache_rd_en,
  input logic             cache_wr_en,
  input logic             lock_q,
  input logic [TAG_W-1:0] lock_line,
  input logic             snp_valid,
  input logic [TAG_W-1:0] snp_line,
  input logic             snp_rsp_valid,
  input logic [TAG_W-1:0] snp_rsp_line,
  input logic             snp_rsp_dvld,
  input logic             rsp_valid,
  input logic             rsp_err
);
  AST_OWN_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
    $rose(own_req) |-> $past(sb_empty)); // R1
  AST_READ_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    cache_rd_en |-> $past(own_gnt)); // R2
  AST_WRITE_UNDER_LOCK: assert property (@(posedge clk) disable iff (rst)
    cache_wr_en |-> lock_q); // R2
  AST_LOCKED_SNOOP_HELD: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && lock_q && snp_line == lock_line) |=> !snp_rsp_valid); // R3
  AST_OTHER_SNOOP_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && !(lock_q && snp_line == lock_line)) |=>
      (snp_rsp_valid && !snp_rsp_dvld && snp_rsp_line == $past(snp_line))); // R4
  AST_DATA_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (snp_rsp_valid && snp_rsp_dvld) |-> !$past(lock_q)); // R5
  AST_REJECT_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (!lock_q && !own_req)); // R9
endmodule

bind atomic_rmw_ctrl atomic_rmw_chk #(.TAG_W(TAG_W)) u_chk (.*);

// File: tb/sim_atomic_rmw_ctrl.sv
`timescale 1ns/1ps
module sim_atomic_rmw_ctrl;
  localparam int LW = 128;
  localparam int DW = 32;
  localparam int GNT_DLY = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [15:0] req_addr = 0;
  logic [DW-1:0] req_opa = 0, req_opb = 0;
  logic rsp_valid, rsp_err, rsp_ok;
  logic [DW-1:0] rsp_old;
  logic sb_empty = 1'b1, own_req, own_gnt;
  logic [11:0] own_line, cache_line, snp_rsp_line;
  logic cache_rd_en, cache_wr_en;
  logic [LW-1:0] cache_wdata, cache_rdata, snp_rsp_data;
  logic snp_valid = 0;
  logic [11:0] snp_line = 0;
  logic snp_rsp_valid, snp_rsp_dvld;

  always #5 clk = ~clk;

  atomic_rmw_ctrl u0 (.*);

  // bench-side models
  logic [LW-1:0] mem [16];
  logic [LW-1:0] ref_mem [16];
  int gcnt, rd_cnt, wr_cnt, own_rise, bad_rd;
  logic granted, own_req_d;

  always @(posedge clk) begin
    if (rst) begin
      own_gnt <= 0; gcnt <= 0; rd_cnt <= 0; wr_cnt <= 0; own_rise <= 0;
      bad_rd <= 0; granted <= 0; own_req_d <= 0; cache_rdata <= '0;
    end else begin
      own_gnt <= 0;
      own_req_d <= own_req;
      if (own_req && !own_req_d) own_rise <= own_rise + 1;
      if (own_req && !own_gnt) begin
        if (gcnt == GNT_DLY) begin own_gnt <= 1; gcnt <= 0; end
        else gcnt <= gcnt + 1;
      end
      if (own_gnt) granted <= 1;
      if (rsp_valid) granted <= 0;
      if (cache_rd_en) begin
        rd_cnt <= rd_cnt + 1;
        cache_rdata <= mem[cache_line[3:0]];
        if (!granted) bad_rd <= bad_rd + 1;
      end
      if (cache_wr_en) begin
        wr_cnt <= wr_cnt + 1;
        mem[cache_line[3:0]] <= cache_wdata;
      end
    end
  end

  int checks = 0, failures = 0;

  task automatic chk(string tag, logic [LW-1:0] act, logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboards
  logic exp_err[$], exp_ok[$];
  logic [DW-1:0] exp_old[$];
  string exp_tag[$];
  logic [11:0] es_line[$];
  logic es_dv[$];
  logic [LW-1:0] es_data[$];
  string es_tag[$];

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_err.size() == 0) chk("R10 unexpected response", 1, 0);
      else begin
        string t;
        t = exp_tag.pop_front();
        chk({t, " err"}, rsp_err, exp_err.pop_front());
        chk({t, " ok"}, rsp_ok, exp_ok.pop_front());
        chk({t, " old"}, rsp_old, exp_old.pop_front());
      end
    end
    if (!rst && snp_rsp_valid) begin
      if (es_line.size() == 0) chk("R3 unexpected snoop response", 1, 0);
      else begin
        string t;
        logic dv;
        logic [LW-1:0] d;
        t = es_tag.pop_front();
        dv = es_dv.pop_front();
        d = es_data.pop_front();
        chk({t, " snoop line"}, snp_rsp_line, es_line.pop_front());
        chk({t, " snoop dvld"}, snp_rsp_dvld, dv);
        if (dv) chk({t, " snoop data"}, snp_rsp_data, d);
      end
    end
  end

  logic [LW-1:0] exp_line;

  task automatic start_op(logic [1:0] op, int ln, int off, logic [DW-1:0] a,
                          logic [DW-1:0] b, string tag);
    logic [LW-1:0] l;
    logic [DW-1:0] o, n;
    logic w;
    forever begin @(negedge clk); if (req_ready) break; end
    if (off + 4 > 16 || op == 2'd3) begin
      exp_err.push_back(1); exp_ok.push_back(0); exp_old.push_back('0);
    end else begin
      l = ref_mem[ln];
      o = l[off*8 +: DW];
      w = 1;
      case (op)
        2'd0: n = o + a;
        2'd1: n = a;
        default: begin w = (o == b); n = w ? a : o; end
      endcase
      l[off*8 +: DW] = n;
      ref_mem[ln] = l;
      exp_line = l;
      exp_err.push_back(0); exp_ok.push_back(w); exp_old.push_back(o);
    end
    exp_tag.push_back(tag);
    req_valid = 1; req_op = op; req_addr = 16'((ln << 4) | off);
    req_opa = a; req_opb = b;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_op();
    forever begin @(negedge clk); if (req_ready) break; end
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_lock();
    while (!own_req) @(negedge clk);
  endtask

  task automatic op_defer(logic [1:0] op, int ln, int off, logic [DW-1:0] a,
                          logic [DW-1:0] b, string tag, int nd);
    start_op(op, ln, off, a, b, tag);
    wait_lock();
    for (int i = 0; i < nd; i++) begin
      es_line.push_back(12'(ln)); es_dv.push_back(1);
      es_data.push_back(exp_line); es_tag.push_back("R5 deferred");
    end
    for (int i = 0; i < nd; i++) begin
      snp_valid = 1; snp_line = 12'(ln);
      @(negedge clk);
    end
    snp_valid = 0;
    finish_op();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      logic [LW-1:0] v;
      for (int w = 0; w < 4; w++) v[w*32 +: 32] = 32'h1111_0000 + 32'(i*16 + w);
      mem[i] = v; ref_mem[i] = v;
    end
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 reset ready", req_ready, 1);
    chk("R10 reset rsp_valid", rsp_valid, 0);
    chk("R10 reset own_req", own_req, 0);
    chk("R10 reset snp_rsp_valid", snp_rsp_valid, 0);

    // store buffer not empty: nothing may start
    sb_empty = 0;
    start_op(2'd0, 2, 4, 32'd5, 0, "R6 add");
    chk("R10 busy after accept", req_ready, 0);
    repeat (6) @(negedge clk);
    chk("R1 no ownership before drain", own_req, 0);
    chk("R1 no read before drain", rd_cnt, 0);
    sb_empty = 1;
    wait_lock();
    es_line.push_back(12'd5); es_dv.push_back(0); es_data.push_back('0); es_tag.push_back("R4 other line");
    es_line.push_back(12'd2); es_dv.push_back(1); es_data.push_back(exp_line); es_tag.push_back("R5 deferred");
    snp_valid = 1; snp_line = 12'd2;
    @(negedge clk);
    chk("R3 locked snoop unanswered", snp_rsp_valid, 0);
    snp_line = 12'd5;
    @(negedge clk);
    snp_valid = 0;
    chk("R4 other line answered next cycle", snp_rsp_valid, 1);
    chk("R2 read waits for grant", rd_cnt, 0);
    finish_op();
    chk("R5 deferred snoop drained", es_line.size(), 0);

    op_defer(2'd1, 3, 12, 32'hCAFE_F00D, 0, "R7 xchg last word", 0);
    op_defer(2'd0, 3, 0, 32'hFFFF_FFFF, 0, "R6 add wrap", 0);
    op_defer(2'd2, 4, 8, 32'h0BAD_BEEF, ref_mem[4][8*8 +: DW], "R8 cas hit", 1);
    begin
      int w0;
      w0 = wr_cnt;
      op_defer(2'd2, 4, 8, 32'h1234_5678, 32'h0, "R8 cas miss", 1);
      chk("R8 cas miss makes no write", wr_cnt, w0);
    end
    begin
      int o0, r0;
      o0 = own_rise; r0 = rd_cnt;
      start_op(2'd0, 5, 13, 32'd1, 0, "R9 line crossing");
      finish_op();
      start_op(2'd3, 5, 0, 32'd1, 0, "R9 bad op code");
      finish_op();
      chk("R9 no ownership on reject", own_rise, o0);
      chk("R9 no cache access on reject", rd_cnt, r0);
    end
    op_defer(2'd1, 6, 4, 32'h7777_0001, 0, "R7 xchg two deferred", 2);
    op_defer(2'd0, 6, 0, 32'd3, 0, "R6 add after drain", 0);

    for (int i = 0; i < 16; i++) chk("R6 R7 R8 final line contents", mem[i], ref_mem[i]);
    chk("R2 no read before grant", bad_rd, 0);
    chk("R10 all responses seen", exp_err.size(), 0);
    chk("R5 all snoop responses seen", es_line.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule